// File: doc/BRIEF.md
# Cascadable Banked Interrupt Controller

This block is one bank of a prioritised interrupt controller. It watches a vector of request lines and records each one in a pending flag. A mask register, a per-line configuration word and one bank-wide mask decide which flags can reach the processor. Each line's configuration word selects its trigger style, its output (normal or fast) and its priority.

Two independent arbiters pick a winner for the normal output and for the fast output. A winner stays latched, and its output stays asserted, until software writes the agreement bit for that output. Only after that write is the next winner chosen. A bank's two outputs can each drive one request line of a parent bank, which builds a two-level tree. The child bank then needs its own agreement write whenever it held a pending line.

The register map uses word addresses:
- 0: pending flags. Reads return the flags. Writing 0 to a bit clears that flag; writing 1 leaves it unchanged.
- 1: line mask.
- 2: normal-output index.
- 3: fast-output index.
- 4: control. Bit 0 is the normal-output agreement, bit 1 is the fast-output agreement, bit 2 is the bank mask.
- 8+n: configuration word of line n. Bit 0 set selects edge triggering, bit 1 set routes the line to the fast output, and bits 2 and up hold the priority.

In the index registers, bits [IDX_W-1:0] hold the line index and the top data bit is set while that output holds a winner. Unmapped addresses read 0. The agreement bits read back as 0.

Top module: `intc_bank`

## Requirements
- R1: After reset, every mask bit is 1, every pending flag is 0, control reads 0, both outputs are low, and each configuration word has bit 0 = 0 (level), bit 1 = 0 (normal output) and an all-ones priority field (lowest).
- R2: A line whose mask bit is 1 is never chosen by either arbiter. Clearing the bit lets it compete.
- R3: Writing address 0 clears each pending flag whose data bit is 0 and leaves flags with a 1 bit unchanged. A level-mode line whose input is still high sets its flag again on the next cycle.
- R4: In edge mode (bit 0 = 1), a 0-to-1 change of the input sets the pending flag. The flag stays set after the input falls.
- R5: In level mode (bit 0 = 0), the pending flag equals the input sampled one clock earlier.
- R6: Configuration bit 1 = 1 sends a line only to the fast output (`fiq_o`). Bit 1 = 0 sends it only to the normal output (`irq_o`).
- R7: Among the unmasked pending lines routed to one output, the arbiter picks the one with the numerically smallest priority field. On a tie, the lowest line index wins.
- R8: Once a winner is latched, its output stays high (unless the bank mask is set) and its index register keeps its value until the agreement bit for that output is written. Later, better requests do not replace it.
- R9: An agreement write releases that output. If the released winner is in edge mode, its pending flag is cleared in the same cycle, unless a new rising edge arrives at the same time.
- R10: While control bit 2 (the bank mask) is 1, both outputs are low. Clearing the bit restores outputs for winners still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | NLINES | Request lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The bench builds the bank with 8 lines and a 3-bit priority field. This makes each line's configuration, full priority ties and index ordering across the whole bank practical to drive by hand. A behavioural model tracks pending flags, masks and both latched winners, and the outputs are compared against it on every cycle. The stimulus mixes edge and level lines on both outputs and includes late better requests during a held winner, bank masking, and clear-by-zero writes that race against a still-high level input.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int OFF_PEND   = 0;
   localparam int OFF_MASK   = 1;
   localparam int OFF_IRQIDX = 2;
   localparam int OFF_FIQIDX = 3;
   localparam int OFF_CTRL   = 4;
   localparam int OFF_LVL    = 8;

   localparam int CB_IRQ_AGREE = 0;
   localparam int CB_FIQ_AGREE = 1;
   localparam int CB_GMASK     = 2;

   localparam int LV_EDGE = 0;
   localparam int LV_FIQ  = 1;
   localparam int LV_PRIO = 2;

   localparam int NCHAN = 2;
endpackage

// File: rtl/intc_line.sv
module intc_line #(
   parameter int PRIO_W = 5,
   localparam int CFG_W = PRIO_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              clr_i,
   input  logic              cfg_we_i,
   input  logic [CFG_W-1:0]  cfg_wdata_i,
   output logic              pend_o,
   output logic              edge_o,
   output logic              fiq_o,
   output logic [PRIO_W-1:0] prio_o
);
   import intc_pkg::*;

   logic             req_q;
   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         pend_o <= 1'b0;
         cfg_q  <= {{PRIO_W{1'b1}}, 2'b00};
      end else begin
         req_q <= req_i;
         if (cfg_we_i) cfg_q <= cfg_wdata_i;
         if (cfg_q[LV_EDGE]) pend_o <= (req_i & ~req_q) | (pend_o & ~clr_i);
         else                pend_o <= req_i;
      end
   end

   assign edge_o = cfg_q[LV_EDGE];
   assign fiq_o  = cfg_q[LV_FIQ];
   assign prio_o = cfg_q[LV_PRIO +: PRIO_W];
endmodule

// File: rtl/intc_channel.sv
module intc_channel #(
   parameter int NLINES = 32,
   parameter int PRIO_W = 5,
   localparam int IDX_W = $clog2(NLINES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NLINES-1:0]          cand_i,
   input  logic [NLINES*PRIO_W-1:0]   prio_i,
   input  logic                       agree_i,
   output logic                       act_o,
   output logic [IDX_W-1:0]           idx_o
);
   logic              found;
   logic [IDX_W-1:0]  best;
   logic [PRIO_W-1:0] best_p;

   always_comb begin
      found  = 1'b0;
      best   = '0;
      best_p = '1;
      for (int i = 0; i < NLINES; i++) begin
         if (cand_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] < best_p)) begin
            found  = 1'b1;
            best   = IDX_W'(i);
            best_p = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o <= 1'b0;
         idx_o <= '0;
      end else if (act_o) begin
         if (agree_i) act_o <= 1'b0;
      end else if (found) begin
         act_o <= 1'b1;
         idx_o <= best;
      end
   end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
   parameter int NLINES = 32,
   parameter int PRIO_W = 5,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] irq_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              fiq_o
);
   import intc_pkg::*;

   localparam int IDX_W = $clog2(NLINES);
   localparam int CFG_W = PRIO_W + 2;

   generate
      if (NLINES < 2 || NLINES > DATA_W) begin : g_bad_lines
         $error("intc_bank: NLINES must lie in 2..DATA_W");
      end
      if (CFG_W > DATA_W || IDX_W >= DATA_W) begin : g_bad_width
         $error("intc_bank: DATA_W too narrow for configuration or index");
      end
      if ((1 << ADDR_W) < OFF_LVL + NLINES) begin : g_bad_addr
         $error("intc_bank: ADDR_W cannot reach every configuration word");
      end
   endgenerate

   logic [NLINES-1:0]              pend, edge_m, fiq_m, clr, mask_q;
   logic [NLINES*PRIO_W-1:0]       prio_flat;
   logic                           gmask_q;
   logic [NCHAN-1:0][NLINES-1:0]   cand;
   logic [NCHAN-1:0]               agree, ch_act;
   logic [NCHAN-1:0][IDX_W-1:0]    ch_idx;
   logic                           wr_ctrl, wr_pend, wr_mask;

   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_pend = bus_we && (bus_addr == ADDR_W'(OFF_PEND));
   assign wr_mask = bus_we && (bus_addr == ADDR_W'(OFF_MASK));

   // clear vector: software clear-by-zero plus auto clear of released edge winners
   always_comb begin
      clr = wr_pend ? ~bus_wdata[NLINES-1:0] : '0;
      for (int c = 0; c < NCHAN; c++) begin
         if (agree[c] && ch_act[c] && edge_m[ch_idx[c]]) clr[ch_idx[c]] = 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < NLINES; g++) begin : g_line
         intc_line #(.PRIO_W(PRIO_W)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (irq_req[g]),
            .clr_i      (clr[g]),
            .cfg_we_i   (bus_we && (bus_addr == ADDR_W'(OFF_LVL + g))),
            .cfg_wdata_i(bus_wdata[CFG_W-1:0]),
            .pend_o     (pend[g]),
            .edge_o     (edge_m[g]),
            .fiq_o      (fiq_m[g]),
            .prio_o     (prio_flat[g*PRIO_W +: PRIO_W])
         );
      end

      for (genvar c = 0; c < NCHAN; c++) begin : g_chan
         assign cand[c]  = pend & ~mask_q & ((c == 1) ? fiq_m : ~fiq_m);
         assign agree[c] = wr_ctrl && bus_wdata[CB_IRQ_AGREE + c];
         intc_channel #(.NLINES(NLINES), .PRIO_W(PRIO_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cand_i (cand[c]),
            .prio_i (prio_flat),
            .agree_i(agree[c]),
            .act_o  (ch_act[c]),
            .idx_o  (ch_idx[c])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         gmask_q <= 1'b0;
      end else begin
         if (wr_mask) mask_q  <= bus_wdata[NLINES-1:0];
         if (wr_ctrl) gmask_q <= bus_wdata[CB_GMASK];
      end
   end

   assign irq_o = ch_act[0] && !gmask_q;
   assign fiq_o = ch_act[1] && !gmask_q;

   always_comb begin
      int unsigned a;
      a = 32'(bus_addr);
      bus_rdata = '0;
      if (a == OFF_PEND) begin
         bus_rdata[NLINES-1:0] = pend;
      end else if (a == OFF_MASK) begin
         bus_rdata[NLINES-1:0] = mask_q;
      end else if (a == OFF_IRQIDX || a == OFF_FIQIDX) begin
         bus_rdata[IDX_W-1:0] = ch_idx[a - OFF_IRQIDX];
         bus_rdata[DATA_W-1]  = ch_act[a - OFF_IRQIDX];
      end else if (a == OFF_CTRL) begin
         bus_rdata[CB_GMASK] = gmask_q;
      end else if (a >= OFF_LVL && a < OFF_LVL + NLINES) begin
         bus_rdata[LV_EDGE] = edge_m[a - OFF_LVL];
         bus_rdata[LV_FIQ]  = fiq_m[a - OFF_LVL];
         bus_rdata[LV_PRIO +: PRIO_W] = prio_flat[(a - OFF_LVL)*PRIO_W +: PRIO_W];
      end
   end
endmodule

// File: rtl/intc_bank_checker.sv
module intc_bank_checker #(
   parameter int NLINES = 32,
   parameter int PRIO_W = 5,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6,
   localparam int IDX_W = $clog2(NLINES)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_we,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [DATA_W-1:0]      bus_wdata,
   input logic [NLINES-1:0]      irq_req,
   input logic                   irq_o,
   input logic                   fiq_o,
   input logic [NLINES-1:0]      pend,
   input logic [NLINES-1:0]      mask_q,
   input logic [NLINES-1:0]      edge_m,
   input logic [NLINES-1:0]      fiq_m,
   input logic [1:0]             ch_act,
   input logic [1:0][IDX_W-1:0]  ch_idx
);
   import intc_pkg::*;

   logic wr_ctrl;
   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));

   a_r10_bank_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[CB_GMASK]) |=> (!irq_o && !fiq_o));

   a_r8_winner_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_act[0] && !(wr_ctrl && bus_wdata[CB_IRQ_AGREE]))
      |=> (ch_act[0] && ch_idx[0] == $past(ch_idx[0])));

   a_r9_edge_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[CB_IRQ_AGREE] && ch_act[0] && edge_m[ch_idx[0]]
       && !irq_req[ch_idx[0]]) |=> !pend[$past(ch_idx[0])]);

   a_r2_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_act[0]) |-> $past(|(pend & ~mask_q & ~fiq_m)));

   a_r6_fiq_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_act[1]) |-> $past(|(pend & ~mask_q & fiq_m)));

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_lvl
         a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
            !edge_m[i] |=> (pend[i] == $past(irq_req[i])));
      end
   endgenerate
endmodule

bind intc_bank intc_bank_checker #(
   .NLINES(NLINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .irq_req(irq_req), .irq_o(irq_o), .fiq_o(fiq_o),
   .pend(pend), .mask_q(mask_q), .edge_m(edge_m), .fiq_m(fiq_m),
   .ch_act(ch_act), .ch_idx(ch_idx)
);

// File: tb/intc_bank_bench.sv
module intc_bank_bench;
   localparam int N  = 8;
   localparam int P  = 3;
   localparam int DW = 32;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_o, fiq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   intc_bank #(.NLINES(N), .PRIO_W(P), .DATA_W(DW), .ADDR_W(AW)) u_intc_bank (
      .clk(clk), .rst_n(rst_n), .irq_req(req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .fiq_o(fiq_o));

   // behavioural reference model
   bit m_pend[N], m_reqq[N], m_mask[N], m_edge[N], m_fiq[N];
   int m_prio[N];
   bit m_gm;
   bit m_act[2];
   int m_idx[2];

   always @(posedge clk) begin : model
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_pend[i] = 0; m_reqq[i] = 0; m_mask[i] = 1;
            m_edge[i] = 0; m_fiq[i] = 0; m_prio[i] = (1 << P) - 1;
         end
         m_gm = 0; m_act = '{0, 0}; m_idx = '{0, 0};
      end else begin
         bit found[2]; int best[2]; bit clr[N]; bit ag[2];
         int a;
         a = int'(bus_addr);
         for (int c = 0; c < 2; c++) begin
            found[c] = 0; best[c] = 0;
            for (int i = 0; i < N; i++)
               if (m_pend[i] && !m_mask[i] && (int'(m_fiq[i]) == c) &&
                   (!found[c] || m_prio[i] < m_prio[best[c]])) begin
                  found[c] = 1; best[c] = i;
               end
            ag[c] = bus_we && a == 4 && bus_wdata[c];
         end
         for (int i = 0; i < N; i++) clr[i] = bus_we && a == 0 && !bus_wdata[i];
         for (int c = 0; c < 2; c++)
            if (ag[c] && m_act[c] && m_edge[m_idx[c]]) clr[m_idx[c]] = 1;
         for (int i = 0; i < N; i++) begin
            if (m_edge[i]) m_pend[i] = (req[i] && !m_reqq[i]) || (m_pend[i] && !clr[i]);
            else           m_pend[i] = req[i];
            m_reqq[i] = req[i];
         end
         for (int c = 0; c < 2; c++) begin
            if (m_act[c]) begin
               if (ag[c]) m_act[c] = 0;
            end else if (found[c]) begin
               m_act[c] = 1; m_idx[c] = best[c];
            end
         end
         if (bus_we && a == 1) for (int i = 0; i < N; i++) m_mask[i] = bus_wdata[i];
         if (bus_we && a == 4) m_gm = bus_wdata[2];
         if (bus_we && a >= 8 && a < 8 + N) begin
            m_edge[a-8] = bus_wdata[0];
            m_fiq[a-8]  = bus_wdata[1];
            m_prio[a-8] = int'(bus_wdata[2 +: P]);
         end
      end
   end

   function automatic logic [DW-1:0] model_read(int a);
      logic [DW-1:0] r;
      r = '0;
      if (a == 0)      for (int i = 0; i < N; i++) r[i] = m_pend[i];
      else if (a == 1) for (int i = 0; i < N; i++) r[i] = m_mask[i];
      else if (a == 2 || a == 3) begin
         r = DW'(m_idx[a-2]);
         r[DW-1] = m_act[a-2];
      end else if (a == 4) r[2] = m_gm;
      else if (a >= 8 && a < 8 + N)
         r = DW'(m_prio[a-8] * 4 + int'(m_fiq[a-8]) * 2 + int'(m_edge[a-8]));
      return r;
   endfunction

   task automatic chk(logic [DW-1:0] act, logic [DW-1:0] exp, string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-cycle output comparison (R8, R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(DW'(irq_o), DW'(m_act[0] && !m_gm), "R8 irq_o vs model");
         chk(DW'(fiq_o), DW'(m_act[1] && !m_gm), "R10 fiq_o vs model");
      end
   end

   task automatic wr(int a, logic [DW-1:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(int a, string tag);
      @(negedge clk);
      bus_addr = AW'(a);
      #1;
      chk(bus_rdata, model_read(a), tag);
   endtask

   task automatic rd_exp(int a, logic [DW-1:0] exp, string tag);
      @(negedge clk);
      bus_addr = AW'(a);
      #1;
      chk(bus_rdata, exp, tag);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      rd_exp(0, 32'h0, "R1 pending");
      rd_exp(1, 32'hFF, "R1 mask");
      rd_exp(4, 32'h0, "R1 control");
      rd_exp(8, 32'h1C, "R1 line config");
      chk(DW'({irq_o, fiq_o}), 0, "R1 outputs");

      // R5 level line 3, R8 index
      wr(1, 32'hF7);
      req[3] = 1'b1;
      idle(3);
      rd_exp(0, 32'h08, "R5 level pending");
      rd_exp(2, 32'h8000_0003, "R8 irq index");
      // R3 clear-by-zero re-asserted by high level input
      wr(0, 32'hF7);
      idle(1);
      rd_exp(0, 32'h08, "R3 level reassert");
      req[3] = 1'b0;
      idle(2);
      rd_exp(0, 32'h00, "R5 level follows low");
      chk(DW'(irq_o), 1, "R8 held without agreement");
      wr(4, 32'h1);
      idle(2);
      chk(DW'(irq_o), 0, "R8 released");

      // R2 masked line ignored
      req[5] = 1'b1;
      idle(3);
      chk(DW'(irq_o), 0, "R2 masked line");
      rd_exp(0, 32'h20, "R2 pending still visible");
      req[5] = 1'b0;
      idle(2);

      // R4 edge line 2, R9 auto clear
      wr(10, 32'h05);
      wr(1, 32'h00);
      @(negedge clk); req[2] = 1'b1;
      @(negedge clk); req[2] = 1'b0;
      idle(2);
      rd_exp(0, 32'h04, "R4 edge latched");
      rd_exp(2, 32'h8000_0002, "R4 edge winner");
      wr(4, 32'h1);
      rd_exp(0, 32'h00, "R9 edge auto clear");

      // R3 clear-by-zero on edge line
      @(negedge clk); req[2] = 1'b1;
      @(negedge clk); req[2] = 1'b0;
      idle(2);
      wr(0, ~32'h04);
      rd_exp(0, 32'h00, "R3 write zero clears");
      wr(0, 32'hFFFF_FFFF);
      rd(0, "R3 write one keeps");
      wr(4, 32'h1);
      idle(2);

      // R7 tie then priority
      req[6] = 1'b1; req[1] = 1'b1;
      idle(3);
      rd_exp(2, 32'h8000_0001, "R7 tie lowest index");
      wr(14, 32'h08);
      wr(4, 32'h1);
      idle(2);
      rd_exp(2, 32'h8000_0006, "R7 smaller priority wins");
      req[6] = 1'b0; req[1] = 1'b0;
      wr(4, 32'h1);
      idle(2);

      // R8 hold against better late request
      req[4] = 1'b1;
      wr(8, 32'h01);
      idle(2);
      @(negedge clk); req[0] = 1'b1;
      @(negedge clk); req[0] = 1'b0;
      idle(2);
      rd_exp(2, 32'h8000_0004, "R8 winner not replaced");
      wr(4, 32'h1);
      idle(2);
      rd_exp(2, 32'h8000_0000, "R8 next after agreement");
      wr(4, 32'h1);
      idle(2);
      rd(0, "R9 pending after second release");
      req[4] = 1'b0;
      wr(4, 32'h1);
      idle(2);

      // R6 fast routing
      wr(15, 32'h02);
      req[7] = 1'b1;
      idle(3);
      chk(DW'({irq_o, fiq_o}), 32'h1, "R6 fast only");
      rd_exp(3, 32'h8000_0007, "R6 fast index");
      // R10 bank mask
      wr(4, 32'h4);
      chk(DW'({irq_o, fiq_o}), 0, "R10 bank mask blocks");
      rd_exp(4, 32'h4, "R10 control readback");
      wr(4, 32'h0);
      chk(DW'(fiq_o), 1, "R10 restore");
      req[7] = 1'b0;
      wr(4, 32'h2);
      idle(2);
      chk(DW'(fiq_o), 0, "R6 fast released");
      rd(3, "R6 fast index after release");
      summary();
   end
endmodule